// File: doc/BRIEF.md
# Coprocessor Mailbox Command Sequencer

This engine lets host logic hand one request to a helper coprocessor and gather its answer, all through a shared register window. The window holds two mailbox registers, one per direction, and a five-word message RAM. A caller supplies a command index and pulses `start`. The engine then takes over. It waits until the coprocessor's outgoing mailbox is empty. It fills the message RAM with a fixed five-word request and rings the doorbell. It polls for an answer a bounded number of times, copies the answer out and always empties the mailbox at the end.

When the answer is in, the engine checks its additive checksum and forms a status word. It also turns the answer's fourth word into an absolute pointer. That word carries a four-bit region selector in its top nibble and a 28-bit offset below it. Every register access goes over a simple master port. The port holds a request until the slave acknowledges it, and read data arrives in the acknowledge cycle.

Top module: `mbox_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done` and `bus_req` are low and `status` is zero.
- R2: The request is written at byte offsets 0x100, 0x104, 0x108, 0x10C and 0x110, in that order. The words are header, opcode, argument count, argument and sum. The header and count are 1. The opcode is 1 for index 0 and 2 for indices 1 and 2. The argument is 2 for index 2 and 1 otherwise. The sum is the 32-bit wrapping total of the first four words.
- R3: A command index of 3 or more makes no bus access. It ends with `status` = 0x8000_0002.
- R4: Before any write, offset 0x14 is read until it returns zero. If `POLL_MAX` reads all return nonzero, the engine ends with `status` = 0x8000_0010 and has made no write.
- R5: After the fifth request word, the value 1 is written to offset 0x10, once.
- R6: After the doorbell, offset 0x14 is read until it returns nonzero, for at most `POLL_MAX` reads. A reply on the last allowed read is accepted. If no reply arrives, `status` = 0x8000_0010, no message word is read, and 0 is still written to 0x14.
- R7: On a reply, the five message words are read back in order. Word i appears on `reply_words[32i+31:32i]`. Then 0 is written to 0x14 and `done` pulses.
- R8: When the reply sum matches, `status` equals the nonzero mailbox value. On a mismatch it is 0x8000_0004.
- R9: When `status` is 1, reply word 3 is decoded as a selector in bits [31:28] and an offset in bits [27:0]. Selector 0 gives `ptr_addr` = `DATA_BASE`+offset with `ptr_in_msg`=0. Selector 1 gives `REG_BASE`+0x100+offset with `ptr_in_msg`=1. In both cases `ptr_valid`=1.
- R10: Any other selector on a successful reply sets `fatal` and leaves `ptr_valid` low.
- R11: Between two consecutive mailbox polls the bus stays idle for exactly `poll_gap` cycles.
- R12: `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` while busy is ignored.
- R13: While `bus_req` is high without `bus_ack`, the address, direction and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one command when idle |
| cmd_sel | input | CMD_W | Command index |
| poll_gap | input | GAP_W | Idle cycles between mailbox polls |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 32 | Result code |
| reply_words | output | 160 | Reply words, word 0 in the low bits |
| ptr_valid | output | 1 | Decoded pointer is usable |
| ptr_in_msg | output | 1 | Pointer targets message RAM (1) or data RAM (0) |
| ptr_addr | output | 32 | Decoded absolute pointer |
| fatal | output | 1 | Reply carried an unknown region selector |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write |
| bus_addr | output | AW | Byte offset in the register window |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
The hardest cases sit at the edges of the two poll loops. One is a reply on exactly the last permitted poll. Another is a mailbox that never clears or never answers, where exactly `POLL_MAX` reads must occur. The bench's register-window slave is scripted with two counters: how many pre-doorbell reads return nonzero, and how many post-doorbell reads return zero. Setting these to 999, 1000 or beyond reaches each edge directly. The slave also adds acknowledge latency and counts idle bus cycles between polls, so the gap and hold rules are measured rather than assumed.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_RDY_RD, S_RDY_GAP, S_MSG_WR, S_BELL,
        S_RSP_RD, S_RSP_GAP, S_MSG_RD, S_CLR, S_FIN
    } seq_state_e;

    localparam int unsigned MSG_WORDS = 5;
    localparam int unsigned NUM_CMDS  = 3;
    localparam logic [31:0] ST_OK      = 32'h0000_0001;
    localparam logic [31:0] ERR_FLAG   = 32'h8000_0000;
    localparam logic [31:0] ST_BAD_CMD = ERR_FLAG | 32'h0000_0002;
    localparam logic [31:0] ST_BAD_SUM = ERR_FLAG | 32'h0000_0004;
    localparam logic [31:0] ST_TIMEOUT = ERR_FLAG | 32'h0000_0010;
endpackage

// File: rtl/mbox_cmd_table.sv
module mbox_cmd_table #(
    parameter int unsigned CMD_W = 4
) (
    input  logic [CMD_W-1:0] cmd,
    input  logic [2:0]       word_idx,
    output logic [31:0]      word
);
    logic [31:0] w [mbox_pkg::MSG_WORDS];

    always_comb begin
        w[0] = 32'd1;
        w[1] = (cmd == CMD_W'(0)) ? 32'd2 - 32'd1 : 32'd2;
        w[2] = 32'd1;
        w[3] = (cmd == CMD_W'(2)) ? 32'd2 : 32'd1;
        w[4] = '0;
        for (int i = 0; i < int'(mbox_pkg::MSG_WORDS) - 1; i++) begin
            w[4] = w[4] + w[i];
        end
        word = (word_idx < 3'(mbox_pkg::MSG_WORDS)) ? w[word_idx] : '0;
    end
endmodule

// File: rtl/mbox_reply_eval.sv
module mbox_reply_eval #(
    parameter logic [31:0] REG_BASE  = 32'h0,
    parameter logic [31:0] DATA_BASE = 32'h0001_0000,
    parameter int unsigned MSG_OFS   = 256
) (
    input  logic [32*mbox_pkg::MSG_WORDS-1:0] words,
    input  logic [31:0]                       code,
    output logic [31:0]                       status,
    output logic                              ptr_valid,
    output logic                              ptr_in_msg,
    output logic [31:0]                       ptr_addr,
    output logic                              fatal
);
    import mbox_pkg::*;

    logic [31:0] sum;
    logic [3:0]  region;
    logic [27:0] ofs;

    always_comb begin
        sum = '0;
        for (int i = 0; i < int'(MSG_WORDS) - 1; i++) begin
            sum = sum + words[32*i +: 32];
        end
        status     = (sum != words[32*4 +: 32]) ? ST_BAD_SUM : code;
        region     = words[32*3+28 +: 4];
        ofs        = words[32*3 +: 28];
        ptr_valid  = 1'b0;
        ptr_in_msg = 1'b0;
        ptr_addr   = '0;
        fatal      = 1'b0;
        if (status == ST_OK) begin
            case (region)
                4'd0: begin
                    ptr_valid = 1'b1;
                    ptr_addr  = DATA_BASE + {4'b0, ofs};
                end
                4'd1: begin
                    ptr_valid  = 1'b1;
                    ptr_in_msg = 1'b1;
                    ptr_addr   = REG_BASE + 32'(MSG_OFS) + {4'b0, ofs};
                end
                default: fatal = 1'b1;
            endcase
        end
    end

    // R10
    always_comb begin
        ptr_excl_chk: assert (!(ptr_valid && fatal));
    end
endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq #(
    parameter int unsigned CMD_W     = 4,
    parameter int unsigned GAP_W     = 16,
    parameter int unsigned AW        = 12,
    parameter int unsigned POLL_MAX  = 1000,
    parameter logic [31:0] REG_BASE  = 32'h0,
    parameter logic [31:0] DATA_BASE = 32'h0001_0000
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic [CMD_W-1:0]                   cmd_sel,
    input  logic [GAP_W-1:0]                   poll_gap,
    output logic                               busy,
    output logic                               done,
    output logic [31:0]                        status,
    output logic [32*mbox_pkg::MSG_WORDS-1:0]  reply_words,
    output logic                               ptr_valid,
    output logic                               ptr_in_msg,
    output logic [31:0]                        ptr_addr,
    output logic                               fatal,
    output logic                               bus_req,
    output logic                               bus_we,
    output logic [AW-1:0]                      bus_addr,
    output logic [31:0]                        bus_wdata,
    input  logic                               bus_ack,
    input  logic [31:0]                        bus_rdata
);
    import mbox_pkg::*;

    localparam int unsigned PCW       = $clog2(POLL_MAX + 1);
    localparam int unsigned MSG_BITS  = 32 * MSG_WORDS;
    localparam logic [AW-1:0] A_TOCOP  = AW'(16);
    localparam logic [AW-1:0] A_TOHOST = AW'(20);
    localparam logic [AW-1:0] A_MSG    = AW'(256);
    localparam logic [2:0]    LAST_W   = 3'(MSG_WORDS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [2:0]        wi;
        logic [PCW-1:0]    polls;
        logic [GAP_W-1:0]  gcnt;
        logic [GAP_W-1:0]  glen;
        logic              tout;
        logic [CMD_W-1:0]  cmd;
        logic [31:0]       code;
        logic [MSG_BITS-1:0] reply;
        logic [31:0]       status;
        logic              pv;
        logic              pmsg;
        logic [31:0]       paddr;
        logic              fatal;
    } seq_t;

    seq_t q, n;

    logic [31:0] tbl_word;
    logic [31:0] ev_status, ev_addr;
    logic        ev_pv, ev_pmsg, ev_fatal;
    logic        cmd_ok, last_poll;

    mbox_cmd_table #(.CMD_W(CMD_W)) u_tbl (
        .cmd      (q.cmd),
        .word_idx (q.wi),
        .word     (tbl_word)
    );

    mbox_reply_eval #(
        .REG_BASE  (REG_BASE),
        .DATA_BASE (DATA_BASE),
        .MSG_OFS   (256)
    ) u_eval (
        .words      (q.reply),
        .code       (q.code),
        .status     (ev_status),
        .ptr_valid  (ev_pv),
        .ptr_in_msg (ev_pmsg),
        .ptr_addr   (ev_addr),
        .fatal      (ev_fatal)
    );

    assign cmd_ok    = (cmd_sel < CMD_W'(NUM_CMDS));
    assign last_poll = ((q.polls + PCW'(1)) == PCW'(POLL_MAX));

    always_comb begin
        n = q;
        unique case (q.st)
            S_IDLE: if (start) begin
                n.reply = '0;
                n.pv    = 1'b0;
                n.pmsg  = 1'b0;
                n.paddr = '0;
                n.fatal = 1'b0;
                n.tout  = 1'b0;
                n.polls = '0;
                n.wi    = '0;
                n.gcnt  = '0;
                n.code  = '0;
                n.glen  = poll_gap;
                n.cmd   = cmd_sel;
                if (cmd_ok) begin
                    n.st = S_RDY_RD;
                end else begin
                    n.status = ST_BAD_CMD;
                    n.st     = S_FIN;
                end
            end
            S_RDY_RD: if (bus_ack) begin
                if (bus_rdata == '0) begin
                    n.st    = S_MSG_WR;
                    n.wi    = '0;
                    n.polls = '0;
                end else if (last_poll) begin
                    n.status = ST_TIMEOUT;
                    n.st     = S_FIN;
                end else begin
                    n.polls = q.polls + PCW'(1);
                    n.gcnt  = '0;
                    if (q.glen != '0) n.st = S_RDY_GAP;
                end
            end
            S_RDY_GAP: begin
                if (q.gcnt == q.glen - GAP_W'(1)) n.st = S_RDY_RD;
                else n.gcnt = q.gcnt + GAP_W'(1);
            end
            S_MSG_WR: if (bus_ack) begin
                if (q.wi == LAST_W) n.st = S_BELL;
                else n.wi = q.wi + 3'd1;
            end
            S_BELL: if (bus_ack) begin
                n.st    = S_RSP_RD;
                n.polls = '0;
            end
            S_RSP_RD: if (bus_ack) begin
                if (bus_rdata != '0) begin
                    n.code = bus_rdata;
                    n.wi   = '0;
                    n.st   = S_MSG_RD;
                end else if (last_poll) begin
                    n.tout = 1'b1;
                    n.st   = S_CLR;
                end else begin
                    n.polls = q.polls + PCW'(1);
                    n.gcnt  = '0;
                    if (q.glen != '0) n.st = S_RSP_GAP;
                end
            end
            S_RSP_GAP: begin
                if (q.gcnt == q.glen - GAP_W'(1)) n.st = S_RSP_RD;
                else n.gcnt = q.gcnt + GAP_W'(1);
            end
            S_MSG_RD: if (bus_ack) begin
                n.reply[32*q.wi +: 32] = bus_rdata;
                if (q.wi == LAST_W) n.st = S_CLR;
                else n.wi = q.wi + 3'd1;
            end
            S_CLR: if (bus_ack) begin
                n.st = S_FIN;
                if (q.tout) begin
                    n.status = ST_TIMEOUT;
                end else begin
                    n.status = ev_status;
                    n.pv     = ev_pv;
                    n.pmsg   = ev_pmsg;
                    n.paddr  = ev_addr;
                    n.fatal  = ev_fatal;
                end
            end
            S_FIN:   n.st = S_IDLE;
            default: n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= S_IDLE;
        end else begin
            q <= n;
        end
    end

    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (q.st)
            S_RDY_RD, S_RSP_RD: begin
                bus_req  = 1'b1;
                bus_addr = A_TOHOST;
            end
            S_MSG_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = A_MSG + AW'({q.wi, 2'b00});
                bus_wdata = tbl_word;
            end
            S_BELL: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = A_TOCOP;
                bus_wdata = 32'd1;
            end
            S_MSG_RD: begin
                bus_req  = 1'b1;
                bus_addr = A_MSG + AW'({q.wi, 2'b00});
            end
            S_CLR: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = A_TOHOST;
            end
            default: ;
        endcase
    end

    assign busy        = (q.st != S_IDLE);
    assign done        = (q.st == S_FIN);
    assign status      = q.status;
    assign reply_words = q.reply;
    assign ptr_valid   = q.pv;
    assign ptr_in_msg  = q.pmsg;
    assign ptr_addr    = q.paddr;
    assign fatal       = q.fatal;

    // R12
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy);

    // R13
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)
                                   && $stable(bus_we) && $stable(bus_wdata)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    fatal_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |-> (status == ST_OK && !ptr_valid));

    // R9
    ptr_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_valid |-> (status == ST_OK));
endmodule

// File: tb/sim_mbox_cmd_seq.sv
module sim_mbox_cmd_seq;
    localparam logic [31:0] RB = 32'h0000_2000;
    localparam logic [31:0] DB = 32'h0004_0000;
    localparam int PMAX = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] cmd_sel = '0;
    logic [15:0] poll_gap = '0;
    logic busy, done, ptr_valid, ptr_in_msg, fatal;
    logic bus_req, bus_we;
    logic [31:0] status, ptr_addr, bus_wdata;
    logic [159:0] reply_words;
    logic [11:0] bus_addr;
    logic bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #4 clk = ~clk;

    mbox_cmd_seq #(.REG_BASE(RB), .DATA_BASE(DB)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_sel(cmd_sel),
        .poll_gap(poll_gap), .busy(busy), .done(done), .status(status),
        .reply_words(reply_words), .ptr_valid(ptr_valid),
        .ptr_in_msg(ptr_in_msg), .ptr_addr(ptr_addr), .fatal(fatal),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // scripted coprocessor side of the register window
    int lat = 0, wcnt = 0;
    int busy_polls = 0, reply_at = 0;
    logic [31:0] reply_code = 32'd1;
    logic [31:0] rep [5];
    logic [31:0] mram [5];
    logic [31:0] exp_msg [5];
    int pre_rd, post_rd, msg_wr, msg_rd, bell_wr, clr_wr, other_acc;
    int wr_bad, order_bad, gap_bad, hold_bad, low_cnt;
    bit phase, last_poll;
    logic [11:0] h_addr; logic h_we; logic [31:0] h_wdata;

    task automatic clear_counts();
        pre_rd = 0; post_rd = 0; msg_wr = 0; msg_rd = 0; bell_wr = 0; clr_wr = 0;
        other_acc = 0; wr_bad = 0; order_bad = 0; gap_bad = 0; hold_bad = 0;
        low_cnt = 0; phase = 0; last_poll = 0; wcnt = 0;
    endtask

    task automatic serve();
        int i;
        i = (int'(bus_addr) - 256) / 4;
        if (bus_we) begin
            last_poll = 0;
            if (bus_addr == 12'h010) begin
                bell_wr++;
                if (msg_wr != 5) order_bad++;
                if (bus_wdata != 32'd1) wr_bad++;
                phase = 1; post_rd = 0;
                for (int k = 0; k < 5; k++) mram[k] = rep[k];
            end else if (bus_addr == 12'h014) begin
                clr_wr++;
                if (bus_wdata != 32'd0) wr_bad++;
            end else if (bus_addr >= 12'h100 && bus_addr <= 12'h110 && bus_addr[1:0] == 2'b00) begin
                if (msg_wr != i) order_bad++;
                if (bus_wdata != exp_msg[i]) wr_bad++;
                mram[i] = bus_wdata;
                msg_wr++;
            end else other_acc++;
        end else begin
            if (bus_addr == 12'h014) begin
                if (last_poll && low_cnt != int'(poll_gap)) gap_bad++;
                last_poll = 1;
                if (!phase) begin
                    pre_rd++;
                    bus_rdata = (pre_rd <= busy_polls) ? 32'hBAD0_0001 : 32'h0;
                end else begin
                    post_rd++;
                    bus_rdata = (post_rd > reply_at) ? reply_code : 32'h0;
                end
            end else if (bus_addr >= 12'h100 && bus_addr <= 12'h110 && bus_addr[1:0] == 2'b00) begin
                last_poll = 0;
                msg_rd++;
                bus_rdata = mram[i];
            end else begin
                last_poll = 0;
                other_acc++;
                bus_rdata = '0;
            end
        end
        low_cnt = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        bus_ack = 1'b0;
        if (rst_n) begin
            if (bus_req) begin
                // R13: request held while waiting
                if (wcnt > 0 && (bus_addr != h_addr || bus_we != h_we || bus_wdata != h_wdata)) hold_bad++;
                if (wcnt >= lat) begin
                    serve();
                    bus_ack = 1'b1;
                    wcnt = 0;
                end else begin
                    h_addr = bus_addr; h_we = bus_we; h_wdata = bus_wdata;
                    wcnt++;
                end
            end else low_cnt++;
        end
    end

    // per-clock busy model (R12)
    bit prev_start = 0, prev_done = 0, exp_busy = 0;
    int busy_bad = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            exp_busy = 0; prev_start = 0; prev_done = 0;
        end else begin
            exp_busy = exp_busy ? !prev_done : prev_start;
            if (busy !== exp_busy) busy_bad++;
            prev_start = start;
            prev_done = done;
        end
    end

    function automatic logic [31:0] sum4(input logic [31:0] a, b, c, d);
        return a + b + c + d;
    endfunction

    task automatic set_reply(input int idx, input logic [31:0] arg, input bit good);
        rep[0] = 32'd2;
        rep[1] = (idx == 0) ? 32'd1 : 32'd2;
        rep[2] = 32'd1;
        rep[3] = arg;
        rep[4] = sum4(rep[0], rep[1], rep[2], rep[3]) + (good ? 32'd0 : 32'd7);
    endtask

    // kind: 0 normal, 1 rejected, 2 ready timeout, 3 reply timeout
    task automatic run(input string tag, input int idx, input int bp, input int ra,
                       input logic [31:0] code, input int g, input int l,
                       input int kind, input int poke);
        logic [31:0] exp_st, a3;
        int waited;
        bit good;
        clear_counts();
        busy_polls = bp; reply_at = ra; reply_code = code; lat = l;
        exp_msg[0] = 32'd1;
        exp_msg[1] = (idx == 0) ? 32'd1 : 32'd2;
        exp_msg[2] = 32'd1;
        exp_msg[3] = (idx == 2) ? 32'd2 : 32'd1;
        exp_msg[4] = sum4(exp_msg[0], exp_msg[1], exp_msg[2], exp_msg[3]);
        busy_bad = 0;
        @(negedge clk);
        cmd_sel = 4'(idx); poll_gap = 16'(g); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (poke > 0 && waited == poke) begin cmd_sel = 4'd0; start = 1'b1; end
            else start = 1'b0;
        end
        start = 1'b0;
        chk(done === 1'b1, {tag, " R7 done reached"}, 32'(done), 32'd1);
        good = (sum4(rep[0], rep[1], rep[2], rep[3]) == rep[4]);
        if (kind == 1) exp_st = 32'h8000_0002;
        else if (kind >= 2) exp_st = 32'h8000_0010;
        else exp_st = good ? code : 32'h8000_0004;
        chk(status == exp_st, {tag, " R8 status"}, status, exp_st);
        if (kind == 1) begin
            chk((pre_rd + msg_wr + bell_wr + clr_wr + other_acc) == 0, {tag, " R3 no bus access"}, 32'(pre_rd + msg_wr), 0);
        end else if (kind == 2) begin
            chk(pre_rd == PMAX, {tag, " R4 ready polls"}, 32'(pre_rd), 32'(PMAX));
            chk((msg_wr + bell_wr + clr_wr) == 0, {tag, " R4 no writes"}, 32'(msg_wr + bell_wr + clr_wr), 0);
        end else begin
            chk(pre_rd == bp + 1, {tag, " R4 ready polls"}, 32'(pre_rd), 32'(bp + 1));
            chk(msg_wr == 5 && wr_bad == 0 && order_bad == 0, {tag, " R2 message words"}, 32'(wr_bad + order_bad), 0);
            chk(bell_wr == 1, {tag, " R5 doorbell once"}, 32'(bell_wr), 1);
            chk(clr_wr == 1, {tag, " R6/R7 mailbox cleared"}, 32'(clr_wr), 1);
            if (kind == 3) begin
                chk(post_rd == PMAX, {tag, " R6 reply polls"}, 32'(post_rd), 32'(PMAX));
                chk(msg_rd == 0, {tag, " R6 no message reads"}, 32'(msg_rd), 0);
            end else begin
                chk(msg_rd == 5, {tag, " R7 message reads"}, 32'(msg_rd), 5);
                for (int k = 0; k < 5; k++)
                    chk(reply_words[32*k +: 32] == rep[k], {tag, " R7 reply word"}, reply_words[32*k +: 32], rep[k]);
                a3 = rep[3];
                if (good && code == 32'd1 && a3[31:28] == 4'd0) begin
                    chk(ptr_valid && !ptr_in_msg && ptr_addr == DB + {4'b0, a3[27:0]},
                        {tag, " R9 data pointer"}, ptr_addr, DB + {4'b0, a3[27:0]});
                end else if (good && code == 32'd1 && a3[31:28] == 4'd1) begin
                    chk(ptr_valid && ptr_in_msg && ptr_addr == RB + 32'h100 + {4'b0, a3[27:0]},
                        {tag, " R9 message pointer"}, ptr_addr, RB + 32'h100 + {4'b0, a3[27:0]});
                end else if (good && code == 32'd1) begin
                    chk(fatal && !ptr_valid, {tag, " R10 fatal"}, 32'(fatal), 1);
                end else begin
                    chk(!ptr_valid && !fatal, {tag, " R9 no pointer on error"}, 32'(ptr_valid), 0);
                end
            end
        end
        chk(gap_bad == 0, {tag, " R11 poll gap"}, 32'(gap_bad), 0);
        chk(hold_bad == 0, {tag, " R13 request hold"}, 32'(hold_bad), 0);
        @(negedge clk);
        chk(!busy && !done, {tag, " R12 idle after done"}, 32'(busy), 0);
        chk(busy_bad == 0, {tag, " R12 busy per clock"}, 32'(busy_bad), 0);
    endtask

    initial begin : watchdog
        wait (cyc > 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        clear_counts();
        set_reply(0, 32'h0, 1'b1);
        repeat (3) @(negedge clk);
        // R1
        chk(!busy && !done && !bus_req, "R1 reset outputs", {29'b0, busy, done, bus_req}, 0);
        chk(status == 32'h0, "R1 reset status", status, 0);
        rst_n = 1'b1;
        @(negedge clk);

        set_reply(0, 32'h1000_0040, 1'b1);
        run("info", 0, 0, 3, 32'd1, 2, 0, 0, 0);
        set_reply(1, 32'h0000_0123, 1'b1);
        run("refresh", 1, 2, 0, 32'd1, 3, 2, 0, 0);
        set_reply(2, 32'h1000_0000, 1'b1);
        run("vendor_err", 2, 1, 1, 32'h8000_0008, 1, 1, 0, 0);
        set_reply(0, 32'h1000_0000, 1'b0);
        run("bad_sum", 0, 0, 2, 32'd1, 0, 0, 0, 0);
        set_reply(1, 32'h5000_0010, 1'b1);
        run("bad_region", 1, 0, 0, 32'd1, 2, 1, 0, 0);
        run("reject3 R3", 3, 0, 0, 32'd1, 0, 0, 1, 0);
        run("reject9 R3", 9, 0, 0, 32'd1, 0, 0, 1, 0);
        run("ready_to", 0, 5000, 0, 32'd1, 0, 0, 2, 0);
        set_reply(1, 32'h0, 1'b1);
        run("reply_to", 1, 0, 5000, 32'd1, 0, 0, 3, 0);
        set_reply(1, 32'h0000_0200, 1'b1);
        run("last_poll R6", 1, 0, PMAX - 1, 32'd1, 0, 0, 0, 0);
        set_reply(2, 32'h1000_0008, 1'b1);
        run("restart_ignored R12", 2, 1, 2, 32'd1, 2, 1, 0, 6);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule